// File: doc/BRIEF.md
# Five-Step Multicycle Instruction Processor

This block is a small programmable processor made of a control unit and a general-purpose datapath. The control unit keeps a 16-bit program counter, an instruction register and a step sequencer. The datapath holds four 16-bit general registers, an operand latch and an incrementing ALU. Every instruction runs through the same five single-cycle steps: fetch, decode, operand fetch, execute and result store. A step runs in its slot even when the instruction has no work for it.

Programs and data live in one shared memory with one address space. The processor reaches it through a single synchronous port. A read returns its word on the clock after the address is presented, and a write is taken on the clock edge where the write enable is high. The instruction set has three working operations: direct-address load, register-to-register increment and direct-address store. A zero opcode, or any undefined one, halts the machine and raises a status output.

Top module: `cpu5_core`

## Requirements
- R1: After reset, every non-halting instruction takes exactly five clock cycles, in the step order fetch, decode, operand fetch, execute, store. A halting instruction takes two cycles (fetch and decode), after which `halted` is high.
- R2: An instruction word has the opcode in bits [15:12], the destination register in bits [11:10] and the source register in bits [9:8]. Opcode 1 is load, 2 is increment and 3 is store. Load and store are followed by one extra word that holds the 16-bit direct address.
- R3: A load writes the memory word at its direct address into the destination register.
- R4: An increment writes the source register plus one, modulo 2^16, into the destination register. Any source and destination pair is allowed, including the same register.
- R5: A store writes the source register to its direct address. This is the only write the instruction makes, and it happens in the fifth step.
- R6: The program counter starts at 0. Each fetch presents the program counter as the memory address, and the counter advances by one for every word consumed, including the address word. Once halted, the address port shows the word after the halting instruction.
- R7: Opcode 0 and opcodes 4 to 15 halt the processor without executing anything. `halted` then stays high and no memory write occurs until the next reset.
- R8: Reset clears the program counter and all four registers, selects the fetch step, drives `halted` and `mem_wr_en` low and presents address 0.
- R9: The memory port is read with a one-cycle latency. The direct address is held on `mem_addr` through the execute and store steps, so load data can be taken in the store step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory word address |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halting opcode has been decoded |

## Verification
Every pairing of the four source and four destination registers is tried in a load, increment, store program with data values 0x0000, 0x1234, 0x7FFF and 0xFFFF. A field swap or a wrong register select shows up as a wrong result word, and the last two values separate a correct wrap from sign or carry mistakes. A store of each register straight after reset shows whether the registers start cleared. Every undefined opcode and the zero opcode is placed ahead of a store, which shows that the halt stops the store before it can write. Cycle counts, write counts and the final address position catch a missing or extra step and a wrong program-counter advance.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;
  localparam int WORD_W   = 16;
  localparam int NUM_REGS = 4;
  localparam int RSEL_W   = $clog2(NUM_REGS);
  localparam int OPC_W    = 4;
  localparam int HDR_W    = OPC_W + 2 * RSEL_W;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPND, ST_EXEC, ST_STORE, ST_HALT
  } step_e;

  typedef enum logic [1:0] {K_HALT, K_LOAD, K_INC, K_STORE} kind_e;

  function automatic kind_e op_kind(input logic [OPC_W-1:0] opc);
    case (opc)
      4'd1:    return K_LOAD;
      4'd2:    return K_INC;
      4'd3:    return K_STORE;
      default: return K_HALT;
    endcase
  endfunction

  function automatic logic needs_addr(input kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction

  function automatic logic [WORD_W-1:0] alu_inc(input logic [WORD_W-1:0] a);
    return a + {{(WORD_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [OPC_W-1:0] hdr_opc(input logic [HDR_W-1:0] h);
    return h[HDR_W-1 -: OPC_W];
  endfunction

  function automatic logic [RSEL_W-1:0] hdr_dst(input logic [HDR_W-1:0] h);
    return h[2*RSEL_W-1 -: RSEL_W];
  endfunction

  function automatic logic [RSEL_W-1:0] hdr_src(input logic [HDR_W-1:0] h);
    return h[RSEL_W-1:0];
  endfunction
endpackage

// File: rtl/cpu5_ctrl.sv
module cpu5_ctrl
  import cpu5_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dec_halt,
  output step_e step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_FETCH;
    end else begin
      case (step)
        ST_FETCH:  step <= ST_DECODE;
        ST_DECODE: step <= dec_halt ? ST_HALT : ST_OPND;
        ST_OPND:   step <= ST_EXEC;
        ST_EXEC:   step <= ST_STORE;
        ST_STORE:  step <= ST_FETCH;
        default:   step <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/cpu5_regs.sv
module cpu5_regs #(
  parameter int NREG = 4,
  parameter int W    = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bank[g] <= '0;
      else if (we && (waddr == SW'(g)))    bank[g] <= wdata;
    end
  end

  assign rdata = bank[raddr];
endmodule

// File: rtl/cpu5_core.sv
module cpu5_core
  import cpu5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);
  step_e             step;
  logic [WORD_W-1:0] pc_q, addr_q, opnd_q, res_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_in;
  kind_e             kind_dec, kind_q;
  logic              dec_halt;
  logic              rf_we;
  logic [WORD_W-1:0] rf_wdata, rf_rd;

  // decode view of the word just returned by memory
  assign hdr_in   = mem_rdata[WORD_W-1 -: HDR_W];
  assign kind_dec = op_kind(hdr_opc(hdr_in));
  assign dec_halt = (kind_dec == K_HALT);
  assign kind_q   = op_kind(hdr_opc(hdr_q));

  cpu5_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_halt (dec_halt),
    .step     (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      hdr_q  <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      res_q  <= '0;
    end else begin
      case (step)
        ST_FETCH:  pc_q <= alu_inc(pc_q);
        ST_DECODE: begin
          hdr_q <= hdr_in;
          if (needs_addr(kind_dec)) pc_q <= alu_inc(pc_q);
        end
        ST_OPND: begin
          addr_q <= mem_rdata;
          opnd_q <= rf_rd;
        end
        ST_EXEC: if (kind_q == K_INC) res_q <= alu_inc(opnd_q);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (step)
      ST_OPND:           mem_addr = mem_rdata;
      ST_EXEC, ST_STORE: mem_addr = addr_q;
      default:           mem_addr = pc_q;
    endcase
  end

  assign mem_wr_en = (step == ST_STORE) && (kind_q == K_STORE);
  assign mem_wdata = opnd_q;
  assign rf_we     = (step == ST_STORE) && ((kind_q == K_LOAD) || (kind_q == K_INC));
  assign rf_wdata  = (kind_q == K_LOAD) ? mem_rdata : res_q;
  assign halted    = (step == ST_HALT);

  cpu5_regs #(.NREG(NUM_REGS), .W(WORD_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (hdr_dst(hdr_q)),
    .wdata (rf_wdata),
    .raddr (hdr_src(hdr_q)),
    .rdata (rf_rd)
  );
endmodule

// File: rtl/cpu5_core_chk.sv
module cpu5_core_chk
  import cpu5_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input step_e             step,
  input logic [WORD_W-1:0] pc_q,
  input logic [WORD_W-1:0] mem_addr,
  input logic              mem_wr_en,
  input logic              halted
);
  assert_fetch_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_FETCH |=> step == ST_DECODE);
  assert_decode_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_DECODE |=> (step == ST_OPND || step == ST_HALT));
  assert_opnd_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_OPND |=> step == ST_EXEC);
  assert_exec_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_EXEC |=> step == ST_STORE);
  assert_store_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_STORE |=> step == ST_FETCH);
  assert_fetch_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_FETCH |-> mem_addr == pc_q);
  assert_pc_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_FETCH |=> (pc_q - $past(pc_q)) == 16'd1);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step == ST_EXEC |=> $stable(mem_addr));
  assert_write_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> step == ST_STORE);
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_wr_en));
endmodule

bind cpu5_core cpu5_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .pc_q      (pc_q),
  .mem_addr  (mem_addr),
  .mem_wr_en (mem_wr_en),
  .halted    (halted)
);

// File: tb/cpu5_core_bench.sv
`timescale 1ns/1ps
module cpu5_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_wr_en, halted;

  logic [15:0] mem [256];
  int          wr_cnt = 0;
  logic [15:0] wr_last = '0;
  int          checks = 0, errors = 0;
  longint      cycles = 0;

  always #2 clk = ~clk;

  cpu5_core u_cpu5_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_wr_en) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      wr_last <= mem_addr;
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=finish", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] enc(input int opc, input int d, input int s);
    return {4'(opc), 2'(d), 2'(s), 8'h00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  // reset, release and count cycles until halted
  task automatic run(output int cyc);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_cnt = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int cyc;
    logic [15:0] vals [4];
    vals[0] = 16'h0000; vals[1] = 16'h1234; vals[2] = 16'h7FFF; vals[3] = 16'hFFFF;

    // reset state
    clear_mem();
    repeat (2) @(negedge clk);
    check("R8 halted in reset", {31'd0, halted}, 32'd0);
    check("R8 wr_en in reset", {31'd0, mem_wr_en}, 32'd0);
    check("R8 addr in reset", {16'd0, mem_addr}, 32'd0);

    // sweep register pairs and values: load, inc, store, halt
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int v = 0; v < 4; v++) begin
          clear_mem();
          mem[0] = enc(1, s, 0); mem[1] = 16'd200;
          mem[2] = enc(2, d, s);
          mem[3] = enc(3, 0, d); mem[4] = 16'd201;
          mem[5] = enc(0, 0, 0);
          mem[200] = vals[v]; mem[201] = 16'hDEAD;
          run(cyc);
          check("R4 R3 inc of loaded value", {16'd0, mem[201]}, {16'd0, 16'(vals[v] + 16'd1)});
          check("R3 source word intact", {16'd0, mem[200]}, {16'd0, vals[v]});
          check("R1 cycle count 3 ops + halt", cyc, 32'd17);
          check("R5 single write", wr_cnt, 32'd1);
          check("R5 write address", {16'd0, wr_last}, 32'd201);
          check("R6 final address", {16'd0, mem_addr}, 32'd6);
        end
      end
    end

    // registers start at zero: store each register straight after reset
    for (int r = 0; r < 4; r++) begin
      clear_mem();
      mem[0] = enc(3, 0, r); mem[1] = 16'd202; mem[2] = enc(0, 0, 0);
      mem[202] = 16'hBEEF;
      run(cyc);
      check("R8 register cleared", {16'd0, mem[202]}, 32'd0);
      check("R1 store + halt cycles", cyc, 32'd7);
      check("R6 final address after store", {16'd0, mem_addr}, 32'd3);
    end

    // zero and undefined opcodes halt before a following store
    for (int opc = 0; opc < 16; opc++) begin
      if (opc >= 1 && opc <= 3) continue;
      clear_mem();
      mem[0] = enc(opc, 1, 2); mem[1] = enc(3, 0, 0); mem[2] = 16'd210;
      mem[210] = 16'h5A5A;
      run(cyc);
      check("R7 halt cycles", cyc, 32'd2);
      repeat (8) @(negedge clk);
      check("R7 halted sticky", {31'd0, halted}, 32'd1);
      check("R7 no write", wr_cnt, 32'd0);
      check("R7 target intact", {16'd0, mem[210]}, 32'h5A5A);
      check("R6 halted address", {16'd0, mem_addr}, 32'd1);
    end

    // R2 R9: chained loads into distinct registers, stored back in reverse
    clear_mem();
    mem[0] = enc(1, 2, 0); mem[1] = 16'd220;
    mem[2] = enc(1, 3, 0); mem[3] = 16'd221;
    mem[4] = enc(3, 0, 3); mem[5] = 16'd222;
    mem[6] = enc(3, 0, 2); mem[7] = 16'd223;
    mem[8] = enc(0, 0, 0);
    mem[220] = 16'hA1B2; mem[221] = 16'hC3D4;
    run(cyc);
    check("R2 R9 load/store R3", {16'd0, mem[222]}, 32'hC3D4);
    check("R2 R9 load/store R2", {16'd0, mem[223]}, 32'hA1B2);
    check("R1 four ops + halt", cyc, 32'd22);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule